// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 interrupt inputs and presents them to a processor through one active-low request line and a small word-addressed register window. Each input has its own trigger type and a 3-bit priority. The controller keeps three views of the inputs: the raw input levels, the active set (level hits plus sticky edge or software latches), and the pending set (active and unmasked). Write-one command words set or clear enable-mask bits and set or clear software latch bits.

Service is a two-step handshake. While idle, the request line goes low whenever anything is pending. Reading the encoding register returns the winning source number times four. The same read enters service, clears that source's latch and releases the request line. A write of any value to the end-of-service register returns the block to idle. The request line then reasserts at once if work remains.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every source control word reads 0x40 (high level, priority 0) and irqN is 1.
- R2: The control word of source n sits at byte offset 4*n. Bits 7:6 select the trigger (00 low level, 01 high level, 10 falling edge, 11 rising edge). Bits 2:0 hold the priority. All other bits read as 0.
- R3: A write to 0x120 sets each mask bit whose data bit is 1. A write to 0x124 clears each mask bit whose data bit is 1. Zero data bits leave the mask alone. The mask reads at 0x114.
- R4: 0x100 reads the raw inputs, 0x104 reads the active set, and 0x108 reads the pending set, which is the active set ANDed with the mask.
- R5: A level source is active exactly while its input sits at the selected level, including right after it has been serviced.
- R6: An edge source latches on its selected edge. It stays active after the input returns, until the latch is acknowledged or cleared.
- R7: The winner is the pending source with the highest priority (7 highest). On a tie the lowest source number wins.
- R8: irqN is 0 exactly when the block is idle and at least one source is pending.
- R9: While idle with something pending, a read of 0x10C returns winner*4, enters service, clears the winner's latch and drives irqN to 1 from the next cycle on. 0x110 then reads the serviced source number.
- R10: A write to 0x130 ends service. irqN reasserts in the following cycle if anything is still pending, and stays 1 otherwise.
- R11: A write to 0x128 sets the latch of each source whose data bit is 1. A write to 0x12C clears it.
- R12: A read of 0x10C with nothing pending returns 0 and changes no state. A read of 0x10C during service returns the serviced number*4 and does not acknowledge again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for the side effects of reads) |
| addr | input | 10 | Byte address of the register |
| wdata | input | 32 | Write data |
| srcIn | input | 32 | Interrupt source inputs |
| rdata | output | 32 | Read data for the addressed register (combinational) |
| irqN | output | 1 | Active-low interrupt request to the processor |

## Verification
The arbitration is tried with one lone source, with two level sources at different priorities, with two sources tied at the same priority, and with a priority-7 level source against a lower-priority software latch. Together these separate the priority compare from the lowest-number tie rule. Edge sources are pulsed and then returned to idle before they are read. This tells a sticky latch apart from a level follower, and rising detection apart from falling detection. A level source is read back after its acknowledge and after end-of-service, which shows that acknowledge clears only latches. Reads of the encoding register are also made while in service and with nothing pending, so that the acknowledge condition is told apart from a bare address decode.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC = 32;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int PRIO_W  = 3;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_RAW  = 10'h100;
  localparam logic [ADDR_W-1:0] OFF_ACT  = 10'h104;
  localparam logic [ADDR_W-1:0] OFF_PEND = 10'h108;
  localparam logic [ADDR_W-1:0] OFF_ENC  = 10'h10C;
  localparam logic [ADDR_W-1:0] OFF_SRV  = 10'h110;
  localparam logic [ADDR_W-1:0] OFF_MASK = 10'h114;
  localparam logic [ADDR_W-1:0] OFF_MSET = 10'h120;
  localparam logic [ADDR_W-1:0] OFF_MCLR = 10'h124;
  localparam logic [ADDR_W-1:0] OFF_SSET = 10'h128;
  localparam logic [ADDR_W-1:0] OFF_SCLR = 10'h12C;
  localparam logic [ADDR_W-1:0] OFF_EOS  = 10'h130;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  typedef enum logic {SVC_IDLE = 1'b0, SVC_BUSY = 1'b1} svc_e;

  typedef struct packed {
    logic             ctrlWr;
    logic [IDX_W-1:0] ctrlIdx;
    logic             maskSet;
    logic             maskClr;
    logic             swSet;
    logic             swClr;
    logic             ack;
  } dpStrobe_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic              busy,
  input  logic [IDX_W-1:0]  servNum,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] pendVec,
  output logic              anyPend,
  output logic [IDX_W-1:0]  winner,
  output logic [DATA_W-1:0] rdata
);
  localparam int CTRL_SPAN_BITS = IDX_W + 2;

  logic [NUM_SRC-1:0]             actVec;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioVec;
  logic [NUM_SRC-1:0][1:0]        trigVec;
  logic [NUM_SRC-1:0]             maskQ;
  logic [PRIO_W-1:0]              bestPrio;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    trig_e             trigQ;
    logic [PRIO_W-1:0] prioQ;
    logic              latchQ, prevQ, edgeHit, levelHit, setL, clrL;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trigQ <= TRIG_HIGH;
        prioQ <= '0;
      end else if (strb.ctrlWr && strb.ctrlIdx == IDX_W'(n)) begin
        trigQ <= trig_e'(wdata[7:6]);
        prioQ <= wdata[PRIO_W-1:0];
      end
    end

    always_comb begin
      edgeHit  = 1'b0;
      levelHit = 1'b0;
      unique case (trigQ)
        TRIG_LOW:  levelHit = ~srcIn[n];
        TRIG_HIGH: levelHit = srcIn[n];
        TRIG_FALL: edgeHit  = prevQ & ~srcIn[n];
        TRIG_RISE: edgeHit  = ~prevQ & srcIn[n];
      endcase
    end

    // a new edge in the acknowledge cycle is kept
    assign setL = edgeHit | (strb.swSet & wdata[n]);
    assign clrL = (strb.swClr & wdata[n]) | (strb.ack && winner == IDX_W'(n));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchQ <= 1'b0;
        prevQ  <= 1'b0;
      end else begin
        latchQ <= (latchQ & ~clrL) | setL;
        prevQ  <= srcIn[n];
      end
    end

    assign actVec[n]  = levelHit | latchQ;
    assign prioVec[n] = prioQ;
    assign trigVec[n] = trigQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else maskQ <= (maskQ | (strb.maskSet ? wdata : '0)) & ~(strb.maskClr ? wdata : '0);
  end

  assign maskVec = maskQ;
  assign pendVec = actVec & maskQ;

  // strict compare keeps the lowest index among equal priorities
  always_comb begin
    winner   = '0;
    bestPrio = '0;
    anyPend  = 1'b0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (pendVec[n] && (!anyPend || prioVec[n] > bestPrio)) begin
        winner   = IDX_W'(n);
        bestPrio = prioVec[n];
        anyPend  = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1:CTRL_SPAN_BITS] == '0 && addr[1:0] == 2'b00) begin
      rdata[7:6]        = trigVec[addr[CTRL_SPAN_BITS-1:2]];
      rdata[PRIO_W-1:0] = prioVec[addr[CTRL_SPAN_BITS-1:2]];
    end else begin
      unique case (addr)
        OFF_RAW:  rdata = srcIn;
        OFF_ACT:  rdata = actVec;
        OFF_PEND: rdata = pendVec;
        OFF_ENC:  rdata = DATA_W'({(busy ? servNum : winner), 2'b00});
        OFF_SRV:  rdata = DATA_W'(servNum);
        OFF_MASK: rdata = maskQ;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              anyPend,
  input  logic [IDX_W-1:0]  winner,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic [IDX_W-1:0]  servNum,
  output logic              irqN
);
  localparam int CTRL_SPAN_BITS = IDX_W + 2;

  svc_e             stateQ;
  logic [IDX_W-1:0] servQ;
  logic             eos;

  always_comb begin
    strb.ctrlWr  = wrEn && addr[ADDR_W-1:CTRL_SPAN_BITS] == '0 && addr[1:0] == 2'b00;
    strb.ctrlIdx = addr[CTRL_SPAN_BITS-1:2];
    strb.maskSet = wrEn && addr == OFF_MSET;
    strb.maskClr = wrEn && addr == OFF_MCLR;
    strb.swSet   = wrEn && addr == OFF_SSET;
    strb.swClr   = wrEn && addr == OFF_SCLR;
    strb.ack     = rdEn && addr == OFF_ENC && stateQ == SVC_IDLE && anyPend;
  end

  assign eos = wrEn && addr == OFF_EOS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SVC_IDLE;
      servQ  <= '0;
    end else if (strb.ack) begin
      stateQ <= SVC_BUSY;
      servQ  <= winner;
    end else if (eos) begin
      stateQ <= SVC_IDLE;
    end
  end

  assign busy    = stateQ == SVC_BUSY;
  assign servNum = servQ;
  assign irqN    = !(stateQ == SVC_IDLE && anyPend);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqN
);
  dpStrobe_t          strb;
  logic               busy, anyPend;
  logic [IDX_W-1:0]   servNum, winner;
  logic [NUM_SRC-1:0] maskVec, pendVec;

  vic_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .anyPend(anyPend), .winner(winner), .strb(strb), .busy(busy),
    .servNum(servNum), .irqN(irqN)
  );

  vic_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wdata(wdata),
    .srcIn(srcIn), .busy(busy), .servNum(servNum), .maskVec(maskVec),
    .pendVec(pendVec), .anyPend(anyPend), .winner(winner), .rdata(rdata)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               irqN,
  input logic               busy,
  input logic               anyPend,
  input logic [IDX_W-1:0]   winner,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] pendVec
);
  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_ENC && !irqN) |=> (irqN && busy));

  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> irqN);

  assert_eos_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_EOS) |=> !busy);

  assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> pendVec[winner]);

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_MSET) |=> ((maskVec & $past(wdata)) == $past(wdata)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_MCLR) |=> ((maskVec & $past(wdata)) == '0));
endmodule

bind vec_irq_ctrl vic_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
  .irqN(irqN), .busy(busy), .anyPend(anyPend), .winner(winner),
  .maskVec(maskVec), .pendVec(pendVec)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
  import vic_pkg::*;

  logic              clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, srcIn = '0;
  logic [31:0]       rdata;
  logic              irqN;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .srcIn(srcIn), .rdata(rdata), .irqN(irqN)
  );

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1; wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wrEn = 1'b0;
  endtask

  // driver: queue the expected word, then issue the read
  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1; expQ.push_back(e); tagQ.push_back(tag); rdEn = 1'b1; addr = a;
    @(posedge clk); #1; rdEn = 1'b0;
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(posedge clk); #1; srcIn = v;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irqN !== e) begin
      fails++;
      $display("FAIL %s irqN got %b exp %b", tag, irqN, e);
    end
  endtask

  // monitor: compare each read against the head of the scoreboard
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string t;
    if (rdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL scoreboard read got %h exp none", rdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s rdata got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog run got hung exp done");
    wrapUp();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b1, "R1");
    busRead(10'h000, 32'h40, "R1 ctrl0");
    busRead(10'h07C, 32'h40, "R1 ctrl31");
    busRead(OFF_MASK, 32'h0, "R1 mask");
    // R2 control words
    busWrite(10'h014, 32'hFFFF_FFFF);
    busRead(10'h014, 32'hC7, "R2 unused bits");
    busWrite(10'h014, 32'h85);
    busRead(10'h014, 32'h85, "R2 fall prio5");
    // R3 mask commands
    busWrite(OFF_MSET, 32'hF0);
    busRead(OFF_MASK, 32'hF0, "R3 set");
    busWrite(OFF_MSET, 32'h03);
    busRead(OFF_MASK, 32'hF3, "R3 set keeps");
    busWrite(OFF_MCLR, 32'h30);
    busRead(OFF_MASK, 32'hC3, "R3 clear");
    busWrite(OFF_MCLR, 32'hFFFF_FFFF);
    busRead(OFF_MASK, 32'h0, "R3 clear all");
    // R4 R5 status views and level modes
    setSrc(32'h0000_0101);
    busRead(OFF_RAW, 32'h101, "R4 raw");
    busRead(OFF_ACT, 32'h101, "R5 high level");
    busRead(OFF_PEND, 32'h0, "R4 masked");
    checkIrq(1'b1, "R8 masked");
    busWrite(OFF_MSET, 32'h1);
    busRead(OFF_PEND, 32'h1, "R4 pending");
    checkIrq(1'b0, "R8 request");
    busWrite(10'h008, 32'h00);
    busRead(OFF_ACT, 32'h105, "R5 low level");
    busWrite(10'h008, 32'h40);
    // R7 R9 R12 R10 service with priorities
    busWrite(10'h020, 32'h43);
    busWrite(OFF_MSET, 32'h100);
    busRead(OFF_ENC, 32'd32, "R7 higher prio");
    checkIrq(1'b1, "R9 released");
    busRead(OFF_SRV, 32'd8, "R9 serviced num");
    busRead(OFF_ENC, 32'd32, "R12 reread busy");
    checkIrq(1'b1, "R12 no reack");
    busWrite(OFF_EOS, 32'h0);
    checkIrq(1'b0, "R10 reassert");
    busRead(OFF_ACT, 32'h101, "R5 level after ack");
    busWrite(10'h000, 32'h43);
    busRead(OFF_ENC, 32'd0, "R7 tie lowest");
    busWrite(OFF_EOS, 32'h0);
    setSrc(32'h0);
    checkIrq(1'b1, "R8 idle none");
    // R6 edge modes
    busWrite(10'h014, 32'hC6);
    busWrite(OFF_MSET, 32'h20);
    setSrc(32'h20);
    setSrc(32'h0);
    busRead(OFF_PEND, 32'h20, "R6 rising sticky");
    checkIrq(1'b0, "R6 request");
    busRead(OFF_ENC, 32'd20, "R9 edge winner");
    busRead(OFF_ACT, 32'h0, "R9 latch cleared");
    busWrite(OFF_EOS, 32'h0);
    checkIrq(1'b1, "R10 no reassert");
    busWrite(10'h018, 32'h81);
    busWrite(OFF_MSET, 32'h40);
    setSrc(32'h40);
    busRead(OFF_ACT, 32'h0, "R6 falling ignores rise");
    setSrc(32'h0);
    busRead(OFF_ACT, 32'h40, "R6 falling sticky");
    busWrite(OFF_SCLR, 32'h40);
    busRead(OFF_ACT, 32'h0, "R11 clear latch");
    checkIrq(1'b1, "R11 cleared idle");
    // R11 software set
    busWrite(OFF_SSET, 32'h8000);
    busRead(OFF_ACT, 32'h8000, "R11 set latch");
    checkIrq(1'b1, "R11 masked");
    busWrite(OFF_MSET, 32'h8000);
    checkIrq(1'b0, "R11 request");
    busRead(OFF_ENC, 32'd60, "R11 enc");
    busRead(OFF_ACT, 32'h0, "R11 ack clears");
    busWrite(OFF_EOS, 32'h0);
    // R12 nothing pending
    busRead(OFF_ENC, 32'd0, "R12 empty enc");
    checkIrq(1'b1, "R12 still idle");
    busRead(OFF_SRV, 32'd15, "R12 serv unchanged");
    // R7 prio7 level against latched prio0
    busWrite(10'h024, 32'h47);
    busWrite(OFF_MSET, 32'h200);
    busWrite(OFF_SSET, 32'h8000);
    setSrc(32'h200);
    busRead(OFF_ENC, 32'd36, "R7 prio7 wins");
    busWrite(OFF_EOS, 32'h0);
    checkIrq(1'b0, "R10 reassert level");
    busRead(OFF_ENC, 32'd36, "R7 again");
    repeat (2) @(negedge clk);
    wrapUp();
  end
endmodule